// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block picks, on every clock, which hardware thread context issues its next operation to a shared execution unit. It keeps a context per thread (program counter, valid flag, blocked flag) and rotates the issue slot among runnable threads with a round-robin pointer. Threads that are stalled or not in use are skipped, so the slot is never spent on a thread that cannot make progress.

When the issuing thread performs a memory load (signalled by `load_i` in its issue cycle), that thread is parked until a load response tagged with its thread ID comes back. The other threads keep issuing in the meantime. Software-visible control is limited to per-thread start and kill requests. Instruction fetch, decode and register files sit outside. The program counter simply advances by one on each issue.

Top module: `barrel_sched`

## Requirements
- R1: The default build holds 128 independent contexts, addressed by a 7-bit thread ID, each with its own program counter, valid flag and blocked flag. All 128 can be runnable at once, and each is issued in turn.
- R2: After reset every context is invalid, `issue_valid_o` is 0 and `resp_err_o` is 0.
- R3: A start request loads `start_pc_i` into the named context, marks it valid and clears its blocked flag. The thread is eligible from the next cycle. Starting a running thread reloads its PC.
- R4: `issue_pc_o` is the issuing thread's current PC, and that PC advances by one after each issue.
- R5: Round-robin selection begins at the thread after the last issued one and wraps from the highest ID to 0. When any other thread is runnable, consecutive issues go to different threads.
- R6: A thread that is invalid or blocked is never issued.
- R7: `issue_valid_o` is 0 in any cycle with no runnable thread, and 1 in any cycle with at least one.
- R8: `load_i` high in a cycle with a valid issue blocks the issuing thread from the next cycle. `load_i` with no issue has no effect.
- R9: A response whose thread ID names a blocked thread clears its blocked flag. The thread may issue from the next cycle.
- R10: A response for a thread that is not blocked (including an invalid one) changes no context and sets `resp_err_o`. `resp_err_o` stays 1 until reset.
- R11: A kill request invalidates the named context. If a start and a kill name the same thread in one cycle, the kill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Start request strobe |
| start_tid_i | input | 7 | Thread to start |
| start_pc_i | input | 32 | Initial PC for the started thread |
| kill_valid_i | input | 1 | Kill request strobe |
| kill_tid_i | input | 7 | Thread to kill |
| load_i | input | 1 | The current issue is a memory load |
| resp_valid_i | input | 1 | Load response strobe |
| resp_tid_i | input | 7 | Thread the load response belongs to |
| issue_valid_o | output | 1 | An issue happens this cycle |
| issue_tid_o | output | 7 | Issuing thread |
| issue_pc_o | output | 32 | PC of the issuing thread |
| resp_err_o | output | 1 | Sticky flag: a response arrived for a thread that was not blocked |

## Verification
The bench goes after the wrap from thread 127 back to 0. A picker that searched from zero instead of from the pointer would starve the high IDs and break the expected rotation. It parks the only runnable thread to check the idle cycle: a design that kept issuing a blocked thread would show a valid issue where none is due. It sends a stray response to a running thread and to an unused one. A design that acted on these would unblock or wake the wrong context, or forget the error flag. It also starts and kills the same thread together, and restarts a thread that is running. A wrong priority there shows up as a thread that keeps issuing, or as a PC that does not reload.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned DEF_THREADS = 128;
  localparam int unsigned DEF_PC_W    = 32;

  // next thread index with wrap
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/sched_rr.sv
module sched_rr #(
  parameter int unsigned N     = 128,
  parameter int unsigned TID_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [TID_W-1:0] ptr_i,
  output logic             gnt_valid_o,
  output logic [TID_W-1:0] gnt_tid_o
);
  localparam int unsigned SUM_W = TID_W + 1;

  logic [SUM_W-1:0] sum;

  // descending scan: the last hit is the nearest to the pointer
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_tid_o   = '0;
    sum         = '0;
    for (int i = N - 1; i >= 0; i--) begin
      sum = {1'b0, ptr_i} + SUM_W'(i);
      if (sum >= SUM_W'(N)) sum = sum - SUM_W'(N);
      if (req_i[sum[TID_W-1:0]]) begin
        gnt_valid_o = 1'b1;
        gnt_tid_o   = sum[TID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sched_ctx.sv
module sched_ctx #(
  parameter int unsigned N     = 128,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned TID_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_valid_i,
  input  logic [TID_W-1:0] start_tid_i,
  input  logic [PC_W-1:0]  start_pc_i,
  input  logic             kill_valid_i,
  input  logic [TID_W-1:0] kill_tid_i,
  input  logic             iss_valid_i,
  input  logic [TID_W-1:0] iss_tid_i,
  input  logic             iss_load_i,
  input  logic             resp_valid_i,
  input  logic [TID_W-1:0] resp_tid_i,
  output logic [N-1:0]     runnable_o,
  output logic [PC_W-1:0]  iss_pc_o,
  output logic             err_o
);
  logic [N-1:0]    valid_q;
  logic [N-1:0]    blocked_q;
  logic [PC_W-1:0] pc_q [N];
  logic            err_q;

  assign runnable_o = valid_q & ~blocked_q;
  assign iss_pc_o   = pc_q[iss_tid_i];
  assign err_o      = err_q;

  for (genvar t = 0; t < N; t++) begin : g_ctx
    logic hit_kill, hit_start, hit_iss, hit_resp;
    assign hit_kill  = kill_valid_i  && (kill_tid_i  == TID_W'(t));
    assign hit_start = start_valid_i && (start_tid_i == TID_W'(t));
    assign hit_iss   = iss_valid_i   && (iss_tid_i   == TID_W'(t));
    assign hit_resp  = resp_valid_i  && (resp_tid_i  == TID_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[t]   <= 1'b0;
        blocked_q[t] <= 1'b0;
      end else if (hit_kill) begin
        valid_q[t]   <= 1'b0;
        blocked_q[t] <= 1'b0;
      end else if (hit_start) begin
        valid_q[t]   <= 1'b1;
        blocked_q[t] <= 1'b0;
      end else if (hit_iss && iss_load_i) begin
        blocked_q[t] <= 1'b1;
      end else if (hit_resp && blocked_q[t]) begin
        blocked_q[t] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pc_q[t] <= '0;
      else if (hit_start) pc_q[t] <= start_pc_i;
      else if (hit_iss)   pc_q[t] <= pc_q[t] + PC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  err_q <= 1'b0;
    else if (resp_valid_i && !blocked_q[resp_tid_i]) err_q <= 1'b1;
  end
endmodule

// File: rtl/barrel_sched.sv
module barrel_sched
  import sched_pkg::*;
#(
  parameter int unsigned NUM_THREADS = DEF_THREADS,
  parameter int unsigned PC_W        = DEF_PC_W,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_valid_i,
  input  logic [TID_W-1:0] start_tid_i,
  input  logic [PC_W-1:0]  start_pc_i,
  input  logic             kill_valid_i,
  input  logic [TID_W-1:0] kill_tid_i,
  input  logic             load_i,
  input  logic             resp_valid_i,
  input  logic [TID_W-1:0] resp_tid_i,
  output logic             issue_valid_o,
  output logic [TID_W-1:0] issue_tid_o,
  output logic [PC_W-1:0]  issue_pc_o,
  output logic             resp_err_o
);
  logic [NUM_THREADS-1:0] runnable;
  logic [TID_W-1:0]       ptr_q;
  logic                   gnt_valid;
  logic [TID_W-1:0]       gnt_tid;

  sched_rr #(.N(NUM_THREADS), .TID_W(TID_W)) u_rr (
    .req_i      (runnable),
    .ptr_i      (ptr_q),
    .gnt_valid_o(gnt_valid),
    .gnt_tid_o  (gnt_tid)
  );

  sched_ctx #(.N(NUM_THREADS), .PC_W(PC_W), .TID_W(TID_W)) u_ctx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_valid_i(start_valid_i),
    .start_tid_i  (start_tid_i),
    .start_pc_i   (start_pc_i),
    .kill_valid_i (kill_valid_i),
    .kill_tid_i   (kill_tid_i),
    .iss_valid_i  (gnt_valid),
    .iss_tid_i    (gnt_tid),
    .iss_load_i   (load_i),
    .resp_valid_i (resp_valid_i),
    .resp_tid_i   (resp_tid_i),
    .runnable_o   (runnable),
    .iss_pc_o     (issue_pc_o),
    .err_o        (resp_err_o)
  );

  // pointer moves just past the thread that issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (gnt_valid) ptr_q <= TID_W'(wrap_next(int'(gnt_tid), NUM_THREADS));
  end

  assign issue_valid_o = gnt_valid;
  assign issue_tid_o   = gnt_tid;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int unsigned N     = 128,
  parameter int unsigned TID_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     runnable,
  input logic             issue_valid_o,
  input logic [TID_W-1:0] issue_tid_o,
  input logic             load_i,
  input logic             start_valid_i,
  input logic [TID_W-1:0] start_tid_i,
  input logic             kill_valid_i,
  input logic [TID_W-1:0] kill_tid_i,
  input logic             resp_err_o
);
  AST_NO_STALLED_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> runnable[issue_tid_o]); // R6

  AST_IDLE_WHEN_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runnable == '0) |-> !issue_valid_o); // R7

  AST_BUSY_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runnable != '0) |-> issue_valid_o); // R7

  AST_SWITCH_THREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && $past(issue_valid_o) && ($countones(runnable) > 1))
      |-> (issue_tid_o != $past(issue_tid_o))); // R5

  AST_LOAD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && load_i
      && !(kill_valid_i && kill_tid_i == issue_tid_o)
      && !(start_valid_i && start_tid_i == issue_tid_o))
      |=> !runnable[$past(issue_tid_o)]); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(resp_err_o) |-> resp_err_o); // R10
endmodule

bind barrel_sched sched_chk #(.N(NUM_THREADS), .TID_W(TID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .runnable     (runnable),
  .issue_valid_o(issue_valid_o),
  .issue_tid_o  (issue_tid_o),
  .load_i       (load_i),
  .start_valid_i(start_valid_i),
  .start_tid_i  (start_tid_i),
  .kill_valid_i (kill_valid_i),
  .kill_tid_i   (kill_tid_i),
  .resp_err_o   (resp_err_o)
);

// File: tb/sim_barrel_sched.sv
`timescale 1ns/1ps
module sim_barrel_sched;
  localparam int N     = 128;
  localparam int TID_W = 7;
  localparam int PC_W  = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_valid = 1'b0;
  logic [TID_W-1:0] start_tid = '0;
  logic [PC_W-1:0]  start_pc = '0;
  logic             kill_valid = 1'b0;
  logic [TID_W-1:0] kill_tid = '0;
  logic             load = 1'b0;
  logic             resp_valid = 1'b0;
  logic [TID_W-1:0] resp_tid = '0;
  logic             issue_valid;
  logic [TID_W-1:0] issue_tid;
  logic [PC_W-1:0]  issue_pc;
  logic             resp_err;

  always #2 clk = ~clk;

  barrel_sched u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .start_valid_i(start_valid), .start_tid_i(start_tid), .start_pc_i(start_pc),
    .kill_valid_i(kill_valid), .kill_tid_i(kill_tid),
    .load_i(load), .resp_valid_i(resp_valid), .resp_tid_i(resp_tid),
    .issue_valid_o(issue_valid), .issue_tid_o(issue_tid), .issue_pc_o(issue_pc),
    .resp_err_o(resp_err)
  );

  typedef struct {
    bit              v;
    int              tid;
    logic [PC_W-1:0] pc;
    string           req;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  // reference state from the requirements
  bit              m_valid [N];
  bit              m_blk   [N];
  logic [PC_W-1:0] m_pc    [N];
  int              m_ptr = 0;
  bit              m_err = 1'b0;
  int              m_lastld = 0;

  // monitor: pop expected issue and compare with the ports
  initial forever begin
    @(chk_ev);
    begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (issue_valid !== e.v || (e.v && (int'(issue_tid) != e.tid || issue_pc !== e.pc))) begin
        bad++;
        $display("FAIL %s: issue v/tid/pc got %0b/%0d/%0h exp %0b/%0d/%0h",
                 e.req, issue_valid, issue_tid, issue_pc, e.v, e.tid, e.pc);
      end
    end
  end

  // driver: one cycle, starting and ending at a falling edge
  task automatic cyc(input string req, input bit ld, input bit st, input int stid,
                     input logic [PC_W-1:0] spc, input bit kl, input int ktid,
                     input bit rv, input int rtid);
    bit pv;
    int pt;
    exp_t e;
    load = ld; start_valid = st; start_tid = TID_W'(stid); start_pc = spc;
    kill_valid = kl; kill_tid = TID_W'(ktid); resp_valid = rv; resp_tid = TID_W'(rtid);
    pv = 1'b0; pt = 0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (m_ptr + i) % N;
      if (m_valid[k] && !m_blk[k]) begin pv = 1'b1; pt = k; break; end
    end
    e.v = pv; e.tid = pt; e.pc = m_pc[pt]; e.req = req;
    q.push_back(e);
    #1;
    ->chk_ev;
    total++;
    if (resp_err !== m_err) begin
      bad++;
      $display("FAIL R10: resp_err got %0b exp %0b", resp_err, m_err);
    end
    // next state
    if (rv) begin
      if (m_blk[rtid]) m_blk[rtid] = 1'b0;
      else             m_err = 1'b1;
    end
    if (pv) begin
      m_pc[pt] = m_pc[pt] + 1;
      if (ld) begin m_blk[pt] = 1'b1; m_lastld = pt; end
      m_ptr = (pt + 1) % N;
    end
    if (st) begin m_valid[stid] = 1'b1; m_blk[stid] = 1'b0; m_pc[stid] = spc; end
    if (kl) begin m_valid[ktid] = 1'b0; m_blk[ktid] = 1'b0; end
    @(posedge clk);
    @(negedge clk);
    load = 1'b0; start_valid = 1'b0; kill_valid = 1'b0; resp_valid = 1'b0;
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung exp done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_blk[i] = 0; m_pc[i] = '0; end
    repeat (3) @(negedge clk);
    total++;
    if (issue_valid !== 1'b0 || resp_err !== 1'b0) begin
      bad++;
      $display("FAIL R2: valid/err got %0b/%0b exp 0/0", issue_valid, resp_err);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle("R2", 2);
    // R3 start threads, including the highest ID for wrap
    cyc("R3", 0, 1, 3, 32'd100, 0, 0, 0, 0);
    cyc("R3", 0, 1, 5, 32'd200, 0, 0, 0, 0);
    cyc("R3", 0, 1, 127, 32'h7ff0, 0, 0, 0, 0);
    idle("R5", 7);
    // R8 load blocks the issuing thread, R6 it is skipped
    cyc("R8", 1, 0, 0, '0, 0, 0, 0, 0);
    idle("R6", 5);
    // R9 response unblocks it
    cyc("R9", 0, 0, 0, '0, 0, 0, 1, m_lastld);
    idle("R9", 4);
    // R10 stray response to a running thread
    cyc("R10", 0, 0, 0, '0, 0, 0, 1, 3);
    idle("R10", 4);
    // R3 restart a running thread
    cyc("R3", 0, 1, 5, 32'd500, 0, 0, 0, 0);
    idle("R3", 3);
    // R11 kill, then kill and start together
    cyc("R11", 0, 0, 0, '0, 1, 3, 0, 0);
    idle("R11", 3);
    cyc("R11", 0, 1, 5, 32'd900, 1, 5, 0, 0);
    idle("R11", 3);
    // R4 one thread left: issues every cycle
    idle("R4", 4);
    // R7 block the last thread: idle
    cyc("R8", 1, 0, 0, '0, 0, 0, 0, 0);
    idle("R7", 3);
    cyc("R8", 1, 0, 0, '0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, '0, 0, 0, 1, 127);
    idle("R9", 2);
    cyc("R10", 0, 0, 0, '0, 0, 0, 1, 60);
    cyc("R11", 0, 0, 0, '0, 1, 127, 0, 0);
    idle("R7", 2);
    cyc("R8", 1, 1, 10, 32'd40, 0, 0, 0, 0);
    idle("R8", 2);
    // R1 all contexts running
    for (int t = 0; t < N; t++) cyc("R1", 0, 1, t, PC_W'(t * 16), 0, 0, 0, 0);
    idle("R1", 2 * N + 3);
    done = 1'b1;
    finish_run();
  end
endmodule